// File: doc/BRIEF.md
# Channel Window Monitor with Shared Interrupt

This block watches the conversion results of four analogue-to-digital channels. Each channel has a window set by two 8-bit levels, a ceiling and a floor. Each new 10-bit result is reduced to its top eight bits and compared against that channel's window. The comparison happens only in the cycle where the channel's result strobe is high.

A result above the ceiling sets that channel's high flag. A result below the floor sets its low flag. All eight flags sit in one byte. They stay set until that byte is read, and the read clears them.

The interrupt output is built for a shared, wired line. While any flag is set whose level is non-zero, the block enables its driver and presents a low. Otherwise it releases the line.

A level of zero switches that side off. The compare cannot set the flag, and a flag that is already set no longer requests the interrupt.

Top module: `win_cmp_irq`

## Requirements
- R1: The compared value of a channel is bits 9 down to 2 of its 10-bit result. Bits 1 and 0 have no effect on any flag.
- R2: On a result strobe, the channel's high flag sets when the compared value is strictly greater than the channel's upper level. An equal value leaves the flag clear.
- R3: On a result strobe, the channel's low flag sets when the compared value is strictly less than the channel's lower level. An equal value leaves the flag clear.
- R4: The flag byte holds the high flag of channel n (n = 1..4) at bit 2n-1 and its low flag at bit 2n-2. So the byte reads, from bit 7 down: H4, L4, H3, L3, H2, L2, H1, L1.
- R5: A level of zero makes that side's comparison inactive, so its flag never sets.
- R6: A set flag stays set across later results, including in-window results, until the flag byte is read.
- R7: A cycle with the read strobe high clears every flag at the next clock edge. The byte presented during the read cycle is the value the reader receives.
- R8: A flag that sets in the same cycle as a read is kept after the read.
- R9: A channel's comparison is made only in a cycle where its result strobe is high. A changed result with no strobe sets nothing.
- R10: When any flag is set whose level is non-zero, `irq_oe` is 1 and `irq_out` is 0. Otherwise `irq_oe` is 0 and `irq_out` is 1. Setting a level to zero withdraws the request of an already-set flag on that side.
- R11: After reset all flags are 0 and the interrupt is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_data | input | 40 | Four 10-bit results; channel n occupies bits 10n-1 down to 10n-10 |
| res_vld | input | 4 | Per-channel result strobe; bit n-1 belongs to channel n |
| lvl_hi | input | 32 | Four 8-bit upper levels; channel n at bits 8n-1 down to 8n-8 |
| lvl_lo | input | 32 | Four 8-bit lower levels, same packing as `lvl_hi` |
| flag_rd | input | 1 | Flag byte read strobe, one cycle per read |
| flags | output | 8 | Sticky flag byte, layout of R4 |
| irq_out | output | 1 | Interrupt pad value, low when requesting |
| irq_oe | output | 1 | Interrupt pad driver enable, high when requesting |

## Verification
The bench targets the exact threshold of each comparison. Results equal to a level must not flag. A result whose top byte equals the level but whose low bits are all ones must not flag either; a design that compared all ten bits, or used a non-strict compare, would raise a flag here.

A read that coincides with a new crossing must keep the new flag and drop the old ones. A design that cleared unconditionally would lose the event.

Zero levels must neither flag nor keep the line pulled. Changed results without a strobe must leave the byte untouched, which a design that compared continuously would fail. Each flag is placed on a different channel, so a swapped bit position shows up directly in the byte.

// File: rtl/win_cmp_irq.sv
module win_cmp_irq #(
  parameter int NCH   = 4,
  parameter int RES_W = 10,
  parameter int LVL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH*RES_W-1:0]   res_data,
  input  logic [NCH-1:0]         res_vld,
  input  logic [NCH*LVL_W-1:0]   lvl_hi,
  input  logic [NCH*LVL_W-1:0]   lvl_lo,
  input  logic                   flag_rd,
  output logic [2*NCH-1:0]       flags,
  output logic                   irq_out,
  output logic                   irq_oe
);

  localparam int FLG_W = 2 * NCH;

  logic [FLG_W-1:0] flag_q;
  logic [FLG_W-1:0] set_vec;
  logic [FLG_W-1:0] arm_vec;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [LVL_W-1:0] smp;
    logic [LVL_W-1:0] hi;
    logic [LVL_W-1:0] lo;

    assign smp = res_data[ch*RES_W + RES_W-1 -: LVL_W];
    assign hi  = lvl_hi[ch*LVL_W +: LVL_W];
    assign lo  = lvl_lo[ch*LVL_W +: LVL_W];

    assign arm_vec[2*ch+1] = |hi;
    assign arm_vec[2*ch]   = |lo;
    assign set_vec[2*ch+1] = res_vld[ch] && (|hi) && (smp > hi);
    assign set_vec[2*ch]   = res_vld[ch] && (|lo) && (smp < lo);

    assert_hi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld[ch] && hi != '0 && smp > hi) |=> flag_q[2*ch+1]);

    assert_lo_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld[ch] && lo != '0 && smp < lo) |=> flag_q[2*ch]);

    assert_zero_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hi == '0 && !flag_q[2*ch+1]) |=> !flag_q[2*ch+1]);

    assert_zero_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lo == '0 && !flag_q[2*ch]) |=> !flag_q[2*ch]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_rd) flag_q <= set_vec;
    else              flag_q <= flag_q | set_vec;
  end

  assign flags   = flag_q;
  assign irq_oe  = |(flag_q & arm_vec);
  assign irq_out = ~irq_oe;

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_rd |=> ((flags & $past(flags)) == $past(flags)));

  assert_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && res_vld == '0) |=> (flags == '0));

  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_rd && res_vld == '0) |=> $stable(flags));

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (!irq_oe && irq_out));

endmodule

// File: tb/tb_win_cmp_irq.sv
module tb_win_cmp_irq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] res_data = '0;
  logic [3:0]  res_vld = '0;
  logic [31:0] lvl_hi = '0;
  logic [31:0] lvl_lo = '0;
  logic        flag_rd = 1'b0;
  logic [7:0]  flags;
  logic        irq_out;
  logic        irq_oe;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  win_cmp_irq dut (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_vld(res_vld),
    .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .flag_rd(flag_rd),
    .flags(flags), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_lvl(int ch, logic [7:0] hi, logic [7:0] lo);
    lvl_hi[ch*8 +: 8] = hi;
    lvl_lo[ch*8 +: 8] = lo;
  endtask

  task automatic post(int ch, logic [9:0] val);
    @(negedge clk);
    res_data[ch*10 +: 10] = val;
    res_vld[ch] = 1'b1;
    @(negedge clk);
    res_vld = '0;
  endtask

  task automatic do_read(output logic [7:0] got);
    @(negedge clk);
    flag_rd = 1'b1;
    got = flags;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 flags", {24'd0, flags}, 32'h00);
    chk("R11 irq_oe", {31'd0, irq_oe}, 32'd0);
    chk("R11 irq_out", {31'd0, irq_out}, 32'd1);
  endtask

  task automatic t_high;
    logic [7:0] got;
    set_lvl(0, 8'h80, 8'h10);
    post(0, 10'h203);
    chk("R1 low bits ignored", {24'd0, flags}, 32'h00);
    chk("R2 equal no flag", {31'd0, irq_oe}, 32'd0);
    post(0, 10'h204);
    chk("R2 above sets H1", {24'd0, flags}, 32'h02);
    chk("R10 irq_oe", {31'd0, irq_oe}, 32'd1);
    chk("R10 irq_out", {31'd0, irq_out}, 32'd0);
    do_read(got);
    chk("R7 read value", {24'd0, got}, 32'h02);
    chk("R7 cleared", {24'd0, flags}, 32'h00);
    chk("R10 released", {31'd0, irq_oe}, 32'd0);
  endtask

  task automatic t_low;
    logic [7:0] got;
    set_lvl(2, 8'hF0, 8'h40);
    post(2, 10'h100);
    chk("R3 equal no flag", {24'd0, flags}, 32'h00);
    post(2, 10'h0FF);
    chk("R3 below sets L3", {24'd0, flags}, 32'h10);
    post(2, 10'h200);
    chk("R6 sticky", {24'd0, flags}, 32'h10);
    do_read(got);
    chk("R7 cleared L3", {24'd0, flags}, 32'h00);
  endtask

  task automatic t_layout;
    logic [7:0] got;
    set_lvl(3, 8'h10, 8'h00);
    set_lvl(1, 8'hFF, 8'hC0);
    post(3, 10'h3FF);
    chk("R4 H4 at bit7", {24'd0, flags}, 32'h80);
    post(1, 10'h000);
    chk("R4 L2 at bit2", {24'd0, flags}, 32'h84);
    do_read(got);
    chk("R7 read both", {24'd0, got}, 32'h84);
  endtask

  task automatic t_zero;
    set_lvl(1, 8'h00, 8'h00);
    post(1, 10'h3FF);
    post(1, 10'h000);
    chk("R5 zero levels no flag", {24'd0, flags}, 32'h00);
    chk("R5 no irq", {31'd0, irq_oe}, 32'd0);
  endtask

  task automatic t_novld;
    set_lvl(0, 8'h20, 8'h00);
    @(negedge clk);
    res_data[9:0] = 10'h3FF;
    repeat (3) @(negedge clk);
    chk("R9 no strobe no flag", {24'd0, flags}, 32'h00);
    post(0, 10'h3FF);
    chk("R9 strobe sets H1", {24'd0, flags}, 32'h02);
  endtask

  task automatic t_collide;
    logic [7:0] got;
    @(negedge clk);
    flag_rd = 1'b1;
    got = flags;
    res_data[39:30] = 10'h3FF;
    res_vld[3] = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    res_vld = '0;
    chk("R8 read value", {24'd0, got}, 32'h02);
    chk("R8 new flag kept", {24'd0, flags}, 32'h80);
  endtask

  task automatic t_mask;
    logic [7:0] got;
    chk("R10 armed", {31'd0, irq_oe}, 32'd1);
    set_lvl(3, 8'h00, 8'h00);
    #1;
    chk("R10 zero level masks", {31'd0, irq_oe}, 32'd0);
    chk("R10 pin released", {31'd0, irq_out}, 32'd1);
    chk("R10 flag still held", {24'd0, flags}, 32'h80);
    do_read(got);
    chk("R7 final clear", {24'd0, flags}, 32'h00);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high();
    t_low();
    t_layout();
    t_zero();
    t_novld();
    t_collide();
    t_mask();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule